// File: doc/BRIEF.md
# Digital Frequency Trim Pulse Adjuster

This block sits between a crystal oscillator's tick stream (nominally 32.768 kHz, delivered as one-cycle enable pulses in the system clock domain) and the seconds divider. It corrects a known frequency error digitally by editing whole pulses. When the correction is positive it adds extra pulses to the stream. When it is negative it removes pulses from it. The corrected stream is brought out, and it also drives a divider that produces one tick per second.

A 3-bit trim code selects the correction, in steps of 10 ppm up to plus or minus 30 ppm. The default code gives no correction. Adjustments are spread evenly across a correction window of one minute of input pulses. A new code is adopted only at the start of a window, so each window always applies one whole setting. The analog load-capacitance trim and the oscillator itself are outside this block.

Top module: `freq_trim_adjuster`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `adj_tick` and `sec_tick` are 0. The first correction window begins with the first `osc_tick` after reset.
- R2: Trim code encoding: bit 2 is the direction (0 = add pulses, 1 = remove pulses) and bits [1:0] are the magnitude m in units of `STEP_PPM` (10 ppm by default). Codes 3'b000 and 3'b100 both give no correction.
- R3: With a positive code of magnitude m, one window of WIN = `TICKS_PER_SEC`*`SECS_PER_WIN` input ticks yields exactly WIN + N(m) output pulses, where N(m) = round(m*`STEP_PPM`*WIN/10^6). With the defaults, N is 20, 39 or 59.
- R4: With a negative code of magnitude m, one window yields exactly WIN - N(m) output pulses, each removal suppressing one input tick.
- R5: An input tick that is not removed appears on `adj_tick` one cycle later. An added pulse is emitted in a later cycle in which `osc_tick` is low.
- R6: Adjustments are evenly spaced: after the first k ticks of a window, exactly floor(k*N(m)/WIN) adjustments have been decided.
- R7: A trim code change made during a window has no effect on that window. It applies from the first tick of the next window.
- R8: `sec_tick` is a single-cycle pulse, raised one cycle after every `TICKS_PER_SEC`-th `adj_tick` pulse, counted continuously from reset.
- R9: When ticks arrive back to back, added pulses are held and released in idle cycles. None are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| trim_code | input | 3 | Signed trim setting: bit 2 direction, bits [1:0] magnitude |
| adj_tick | output | 1 | Corrected pulse stream |
| sec_tick | output | 1 | One-cycle pulse per second of corrected pulses |

## Verification
The bench runs whole windows at every one of the eight codes and compares pulse counts. A wrong sign decode or magnitude scaling therefore shows up as an offset in the count, and if the negative-zero code were decoded as a correction, its count would move off WIN. It counts pulses partway through a window to catch adjustments that are bunched at the window start or the end instead of spread out. It also changes the code in mid-window, where a design that adopts the code immediately would produce a count between the two settings. Bursts of back-to-back ticks check that a design emitting added pulses over a live tick, or dropping held pulses, comes out one pulse short. The running seconds count shows whether the divider counts raw ticks instead of corrected ones.

// File: rtl/ftrim_pkg.sv
package ftrim_pkg;

    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } trim_code_t;

    typedef enum logic [1:0] {
        ADJ_NONE   = 2'd0,
        ADJ_INSERT = 2'd1,
        ADJ_DROP   = 2'd2
    } adj_kind_t;

    localparam int unsigned MAG_LEVELS = 4;

    // Adjustments per window for one magnitude step count, rounded to nearest.
    function automatic logic [63:0] adj_events(input int unsigned mag,
                                               input int unsigned step_ppm,
                                               input int unsigned win);
        logic [63:0] prod;
        prod = 64'(mag) * 64'(step_ppm) * 64'(win);
        return (prod + 64'd500000) / 64'd1000000;
    endfunction

endpackage

// File: rtl/trim_window_ctrl.sv
module trim_window_ctrl
    import ftrim_pkg::*;
#(
    parameter int unsigned WIN      = 1966080,
    parameter int unsigned STEP_PPM = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_in,
    input  trim_code_t trim_in,
    output adj_kind_t  adj_kind
);
    localparam int unsigned WIN_W = $clog2(WIN);
    localparam int unsigned ACC_W = WIN_W + 1;

    logic [ACC_W-1:0] ev_lut [MAG_LEVELS];

    for (genvar g = 0; g < MAG_LEVELS; g++) begin : g_lut
        assign ev_lut[g] = ACC_W'(adj_events(g, STEP_PPM, WIN));
    end

    logic [WIN_W-1:0] win_cnt;
    logic [ACC_W-1:0] acc;
    trim_code_t       active;

    logic             win_start;
    trim_code_t       cur_code;
    logic [ACC_W-1:0] n_sel;
    logic [ACC_W-1:0] acc_base;
    logic [ACC_W-1:0] acc_sum;
    logic             hit;

    always_comb begin
        win_start = (win_cnt == '0);
        cur_code  = win_start ? trim_in : active;
        n_sel     = ev_lut[cur_code.mag];
        acc_base  = win_start ? '0 : acc;
        acc_sum   = acc_base + n_sel;
        hit       = tick_in && (acc_sum >= ACC_W'(WIN));
        if (!hit)
            adj_kind = ADJ_NONE;
        else if (cur_code.neg)
            adj_kind = ADJ_DROP;
        else
            adj_kind = ADJ_INSERT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            acc     <= '0;
            active  <= '0;
        end else if (tick_in) begin
            win_cnt <= (win_cnt == WIN_W'(WIN - 1)) ? '0 : win_cnt + 1'b1;
            acc     <= hit ? acc_sum - ACC_W'(WIN) : acc_sum;
            if (win_start)
                active <= trim_in;
        end
    end

    AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        win_cnt < WIN_W'(WIN));                                       // R6
    AST_ACC_BELOW_WIN: assert property (@(posedge clk) disable iff (rst)
        acc < ACC_W'(WIN));                                           // R6
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !(tick_in && win_start) |=> $stable(active));                 // R7
    AST_ADJ_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (adj_kind != ADJ_NONE) |-> tick_in);                          // R6

endmodule

// File: rtl/pulse_editor.sv
module pulse_editor
    import ftrim_pkg::*;
#(
    parameter int unsigned PEND_W = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_in,
    input  adj_kind_t adj_kind,
    output logic      adj_tick
);
    logic [PEND_W-1:0] pend;
    logic              drop;
    logic              ins;
    logic              flush;
    logic              adj_d;
    logic [PEND_W-1:0] pend_d;

    always_comb begin
        drop   = tick_in && (adj_kind == ADJ_DROP);
        ins    = tick_in && (adj_kind == ADJ_INSERT);
        flush  = !tick_in && (pend != '0);
        adj_d  = (tick_in && !drop) || flush;
        pend_d = pend + PEND_W'(ins) - PEND_W'(flush);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            adj_tick <= 1'b0;
        end else begin
            pend     <= pend_d;
            adj_tick <= adj_d;
        end
    end

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (tick_in && adj_kind == ADJ_DROP) |=> !adj_tick);             // R4
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (tick_in && adj_kind != ADJ_DROP) |=> adj_tick);              // R5
    AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick_in && pend != '0) |=> adj_tick);                       // R5
    AST_PEND_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pend == '1) |-> !ins);                                       // R9

endmodule

// File: rtl/sec_divider.sv
module sec_divider #(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic sec_tick
);
    localparam int unsigned SEC_W = $clog2(TICKS_PER_SEC);

    logic [SEC_W-1:0] cnt;
    logic             last;

    assign last = (cnt == SEC_W'(TICKS_PER_SEC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= pulse_in && last;
            if (pulse_in)
                cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    AST_SEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);                                      // R8
    AST_SEC_FROM_PULSE: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> $past(pulse_in));                                // R8

endmodule

// File: rtl/freq_trim_adjuster.sv
module freq_trim_adjuster
    import ftrim_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned SECS_PER_WIN  = 60,
    parameter int unsigned STEP_PPM      = 10,
    parameter int unsigned PEND_W        = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic [2:0] trim_code,
    output logic       adj_tick,
    output logic       sec_tick
);
    localparam int unsigned WIN = TICKS_PER_SEC * SECS_PER_WIN;

    trim_code_t tc;
    adj_kind_t  kind;

    assign tc = trim_code_t'(trim_code);

    trim_window_ctrl #(
        .WIN      (WIN),
        .STEP_PPM (STEP_PPM)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (osc_tick),
        .trim_in  (tc),
        .adj_kind (kind)
    );

    pulse_editor #(
        .PEND_W (PEND_W)
    ) u_edit (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (osc_tick),
        .adj_kind (kind),
        .adj_tick (adj_tick)
    );

    sec_divider #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_sec (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (adj_tick),
        .sec_tick (sec_tick)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!adj_tick && !sec_tick));                            // R1

endmodule

// File: tb/sim_freq_trim_adjuster.sv
module sim_freq_trim_adjuster;
    localparam int TPS = 50;
    localparam int SPW = 10;
    localparam int WIN = TPS * SPW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic [2:0] trim_code = 3'b000;
    logic       adj_tick;
    logic       sec_tick;

    int n_chk = 0;
    int n_bad = 0;
    int adj_cnt = 0;
    int sec_cnt = 0;
    bit done = 1'b0;

    // code (3 bits) + expected pulses per window of 500 ticks (N = 5/10/15)
    localparam logic [12:0] VEC [8] = '{
        {3'b000, 10'd500}, {3'b001, 10'd505}, {3'b010, 10'd510},
        {3'b011, 10'd515}, {3'b100, 10'd500}, {3'b101, 10'd495},
        {3'b110, 10'd490}, {3'b111, 10'd485}
    };

    always #4 clk = ~clk;

    freq_trim_adjuster #(
        .TICKS_PER_SEC (TPS),
        .SECS_PER_WIN  (SPW),
        .STEP_PPM      (10000),
        .PEND_W        (3)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .trim_code (trim_code),
        .adj_tick  (adj_tick),
        .sec_tick  (sec_tick)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (adj_tick) adj_cnt++;
            if (sec_tick) sec_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        osc_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_burst(input int n);
        @(negedge clk) osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int a0;
        int s0;
        int tot;
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 adj_tick in reset", int'(adj_tick), 0);
        chk("R1 sec_tick in reset", int'(sec_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 adj_tick after release", int'(adj_tick), 0);

        // R5: one-cycle latency of a passed tick
        do_reset();
        trim_code = 3'b000;
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk);
        chk("R5 tick appears next cycle", int'(adj_tick), 1);
        osc_tick = 1'b0;
        @(negedge clk);
        chk("R5 single pulse", int'(adj_tick), 0);

        // R2 R3 R4: one window per code, walked from the vector table
        do_reset();
        s0 = sec_cnt;
        tot = 0;
        for (int i = 0; i < 8; i++) begin
            trim_code = VEC[i][12:10];
            a0 = adj_cnt;
            run_ticks(WIN);
            chk($sformatf("R2/R3/R4 code %03b window count", VEC[i][12:10]),
                adj_cnt - a0, int'(VEC[i][9:0]));
            tot += adj_cnt - a0;
        end
        // R8: seconds counted from corrected pulses
        chk("R8 seconds after table", sec_cnt - s0, tot / TPS);

        // R7: mid-window change ignored until next window
        trim_code = 3'b000;
        a0 = adj_cnt;
        run_ticks(100);
        trim_code = 3'b011;
        run_ticks(WIN - 100);
        chk("R7 window with mid change", adj_cnt - a0, WIN);
        a0 = adj_cnt;
        run_ticks(WIN);
        chk("R7 next window uses new code", adj_cnt - a0, WIN + 15);

        // R6: even spacing within a window
        trim_code = 3'b001;
        a0 = adj_cnt;
        run_ticks(250);
        chk("R6 half window +5", adj_cnt - a0, 252);
        a0 = adj_cnt;
        run_ticks(250);
        chk("R6 second half +5", adj_cnt - a0, 253);
        trim_code = 3'b111;
        a0 = adj_cnt;
        run_ticks(100);
        chk("R6 fifth of window -15", adj_cnt - a0, 97);
        a0 = adj_cnt;
        run_ticks(400);
        chk("R6 remainder -15", adj_cnt - a0, 388);

        // R9: back-to-back ticks, added pulse deferred but kept
        do_reset();
        trim_code = 3'b011;
        a0 = adj_cnt;
        run_burst(40);
        chk("R9 burst +15 keeps added pulse", adj_cnt - a0, 41);
        do_reset();
        trim_code = 3'b111;
        a0 = adj_cnt;
        run_burst(40);
        chk("R4 burst -15 removes one", adj_cnt - a0, 39);
        // R8: single-cycle seconds pulse count over a 0 ppm run
        do_reset();
        trim_code = 3'b100;
        s0 = sec_cnt;
        run_ticks(3 * TPS);
        chk("R8 three seconds at zero trim", sec_cnt - s0, 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule